// File: doc/BRIEF.md
# JTAG Output Launch Timing Controller

This block sets the moment at which the TMS and TDI pins of a JTAG master change, measured against the test clock that comes back from the target. A shift engine supplies the next TMS and TDI bits. The block watches a return-clock source for the chosen edge and takes a copy of those bits on that edge. The copy then passes through a programmable link pipeline, and each pin gets its own fine delay before it drives the output. All delays count base-clock cycles.

The return-clock source is either the external return-clock pin or an internal loop-back of the emitted TCK. The loop-back is for targets that do not return a clock, and it has a short selectable delay. Timing settings are taken in only while the shift engine reports idle, so a shift in progress always runs with one fixed timing. The block also merges two termination requests into one termination enable.

Top module: `jtag_launch_timer`

## Requirements
- R1: After reset, tms_o and tdi_o are both 1 and the held settings are link 3, offsets 0, rising edge, external return clock.
- R2: In external mode with rising launch (fall_launch_i=0), a 0-to-1 change of rclk_i made between clock edges carries the tms_nxt_i/tdi_nxt_i values present at the next edge to tms_o exactly link+tms_offset+1 clock edges later.
- R3: With fall_launch_i=1, only a 1-to-0 change of the source launches bits, and a 0-to-1 change leaves both outputs unchanged.
- R4: link_dly_i is clamped to the range 3 to 5: values below 3 act as 3 and values above 5 act as 5.
- R5: tms_ofs_i and tdi_ofs_i (0 to 7) delay each pin independently, so tdi_o follows after link+tdi_offset+1 edges when the two offsets differ.
- R6: When the two offsets are equal, tdi_o changes one edge after tms_o, and the two never change on the same edge.
- R7: With no_rclk_i=1, the source is tck_i delayed by 1+byp_dly_i registers (byp_dly_i 0 to 3), so the output latency becomes link+offset+byp_dly_i+2 edges.
- R8: With no_rclk_i=1, changes on rclk_i have no effect on either output.
- R9: All timing settings (link, offsets, bypass delay, edge, source) are sampled only while busy_i=0, and changes made while busy_i=1 are ignored until busy_i falls.
- R10: term_en_o is 1 whenever term_tck_i or term_tdi_i is 1, and 0 only when both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy_i | input | 1 | Shift engine active; settings are frozen while high |
| no_rclk_i | input | 1 | 1 selects the internal TCK loop-back as the source |
| rclk_i | input | 1 | Return clock from the target, synchronous to clk |
| tck_i | input | 1 | Emitted TCK level, used by the loop-back |
| fall_launch_i | input | 1 | 0 launches on rising source edges, 1 on falling |
| link_dly_i | input | 3 | Link pipeline depth in cycles (3 to 5 effective) |
| tms_ofs_i | input | 3 | Extra TMS delay in cycles |
| tdi_ofs_i | input | 3 | Extra TDI delay in cycles |
| byp_dly_i | input | 2 | Extra loop-back delay in cycles |
| tms_nxt_i | input | 1 | Next TMS bit from the shift engine |
| tdi_nxt_i | input | 1 | Next TDI bit from the shift engine |
| term_tck_i | input | 1 | Termination request for the return-clock line |
| term_tdi_i | input | 1 | Termination request for the data line |
| tms_o | output | 1 | Launched TMS |
| tdi_o | output | 1 | Launched TDI |
| term_en_o | output | 1 | Shared termination enable |

## Verification
A table of settings is run in turn: link values in range and on both sides of it, unequal offsets in both orders, equal offsets including the largest, and both launch edges. For each setting the bench measures the exact edge count to each output change. This shows whether a delay fault comes from the link pipeline, the offset counters or the separation rule. In falling-edge mode a rising edge is applied first with fresh bits, and no change is allowed. Loop-back runs with the smallest and largest bypass delay show the extra registers on that path, and toggling rclk_i in loop-back mode shows that the external pin is cut off. A settings change made while busy must leave the old latencies in force.

// File: rtl/jlt_pkg.sv
package jlt_pkg;
    localparam int LINK_W = 3;
    localparam int OFS_W  = 3;
    localparam int BYP_W  = 2;

    typedef struct packed {
        logic              no_rclk;
        logic              fall;
        logic [BYP_W-1:0]  byp;
        logic [LINK_W-1:0] link;
        logic [OFS_W-1:0]  tms_ofs;
        logic [OFS_W-1:0]  tdi_ofs;
    } cfg_t;
endpackage

// File: rtl/jlt_edge_src.sv
// Picks the return-clock source and flags the selected edge.
module jlt_edge_src #(
    parameter int BYP_W = 2,
    localparam int BYP_DEPTH = 2 ** BYP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             no_rclk_i,
    input  logic             fall_i,
    input  logic [BYP_W-1:0] byp_sel_i,
    input  logic             rclk_i,
    input  logic             tck_i,
    output logic             launch_o
);
    typedef struct packed {
        logic [BYP_DEPTH-1:0] line;
        logic                 src;
    } st_t;

    st_t  st_d, st_q;
    logic src_now;

    always_comb begin
        st_d      = st_q;
        // loop-back line: tap 0 is one register behind tck_i
        st_d.line = {st_q.line[BYP_DEPTH-2:0], tck_i};
        src_now   = no_rclk_i ? st_q.line[byp_sel_i] : rclk_i;
        st_d.src  = src_now;
        launch_o  = fall_i ? (st_q.src & ~src_now) : (~st_q.src & src_now);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/jlt_link_pipe.sv
// Fixed-depth shift pipeline with a selectable output tap.
module jlt_link_pipe #(
    parameter int DEPTH  = 5,
    parameter int W      = 2,
    parameter int LINK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic [W-1:0]      bits_i,
    input  logic [LINK_W-1:0] link_i,
    output logic              vld_o,
    output logic [W-1:0]      bits_o
);
    logic [DEPTH-1:0][W:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = {vld_i, bits_i};
        for (int i = 1; i < DEPTH; i++) stg_d[i] = stg_q[i-1];
        vld_o  = 1'b0;
        bits_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (LINK_W'(i + 1) == link_i) begin
                vld_o  = stg_q[i][W];
                bits_o = stg_q[i][W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end
endmodule

// File: rtl/jlt_ofs_timer.sv
// Per-pin fine offset: holds a launched bit for a counted number of cycles.
module jlt_ofs_timer #(
    parameter int   CNT_W   = 4,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tap_vld_i,
    input  logic             tap_bit_i,
    input  logic [CNT_W-1:0] ofs_i,
    output logic             out_o
);
    typedef struct packed {
        logic             out;
        logic             pend;
        logic             bit_h;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tap_vld_i) begin
            if (ofs_i == '0) begin
                st_d.out  = tap_bit_i;
                st_d.pend = 1'b0;
            end else begin
                st_d.pend  = 1'b1;
                st_d.cnt   = ofs_i - CNT_W'(1);
                st_d.bit_h = tap_bit_i;
            end
        end else if (st_q.pend) begin
            if (st_q.cnt == '0) begin
                st_d.out  = st_q.bit_h;
                st_d.pend = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
        out_o = st_q.out;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.out <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/jtag_launch_timer.sv
module jtag_launch_timer #(
    parameter int LINK_MIN = 3,
    parameter int LINK_MAX = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      busy_i,
    input  logic                      no_rclk_i,
    input  logic                      rclk_i,
    input  logic                      tck_i,
    input  logic                      fall_launch_i,
    input  logic [jlt_pkg::LINK_W-1:0] link_dly_i,
    input  logic [jlt_pkg::OFS_W-1:0]  tms_ofs_i,
    input  logic [jlt_pkg::OFS_W-1:0]  tdi_ofs_i,
    input  logic [jlt_pkg::BYP_W-1:0]  byp_dly_i,
    input  logic                      tms_nxt_i,
    input  logic                      tdi_nxt_i,
    input  logic                      term_tck_i,
    input  logic                      term_tdi_i,
    output logic                      tms_o,
    output logic                      tdi_o,
    output logic                      term_en_o
);
    import jlt_pkg::*;

    localparam int CNT_W = OFS_W + 1;
    localparam int NSIG  = 2;   // index 1 = TMS, index 0 = TDI

    cfg_t cfg_d, cfg_q;
    logic                      launch;
    logic                      tap_vld;
    logic [NSIG-1:0]           tap_bits;
    logic [NSIG-1:0][CNT_W-1:0] ofs_eff;
    logic [NSIG-1:0]           pin_out;

    // settings capture, clamped, idle only
    always_comb begin
        cfg_d = cfg_q;
        if (!busy_i) begin
            cfg_d.no_rclk = no_rclk_i;
            cfg_d.fall    = fall_launch_i;
            cfg_d.byp     = byp_dly_i;
            cfg_d.tms_ofs = tms_ofs_i;
            cfg_d.tdi_ofs = tdi_ofs_i;
            if (link_dly_i < LINK_W'(LINK_MIN))      cfg_d.link = LINK_W'(LINK_MIN);
            else if (link_dly_i > LINK_W'(LINK_MAX)) cfg_d.link = LINK_W'(LINK_MAX);
            else                                     cfg_d.link = link_dly_i;
        end
        ofs_eff[1] = {1'b0, cfg_q.tms_ofs};
        ofs_eff[0] = (cfg_q.tdi_ofs == cfg_q.tms_ofs)
                   ? ({1'b0, cfg_q.tdi_ofs} + CNT_W'(1))
                   : {1'b0, cfg_q.tdi_ofs};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            cfg_q.link <= LINK_W'(LINK_MIN);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    jlt_edge_src #(.BYP_W(BYP_W)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .no_rclk_i (cfg_q.no_rclk),
        .fall_i    (cfg_q.fall),
        .byp_sel_i (cfg_q.byp),
        .rclk_i    (rclk_i),
        .tck_i     (tck_i),
        .launch_o  (launch)
    );

    jlt_link_pipe #(.DEPTH(LINK_MAX), .W(NSIG), .LINK_W(LINK_W)) u_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (launch),
        .bits_i ({tms_nxt_i, tdi_nxt_i}),
        .link_i (cfg_q.link),
        .vld_o  (tap_vld),
        .bits_o (tap_bits)
    );

    for (genvar g = 0; g < NSIG; g++) begin : g_tim
        jlt_ofs_timer #(.CNT_W(CNT_W), .RST_VAL(1'b1)) u_tim (
            .clk       (clk),
            .rst_n     (rst_n),
            .tap_vld_i (tap_vld),
            .tap_bit_i (tap_bits[g]),
            .ofs_i     (ofs_eff[g]),
            .out_o     (pin_out[g])
        );
    end

    assign tms_o     = pin_out[1];
    assign tdi_o     = pin_out[0];
    assign term_en_o = term_tck_i | term_tdi_i;
endmodule

// File: rtl/jlt_checker.sv
module jlt_checker #(
    parameter int LINK_MIN = 3,
    parameter int LINK_MAX = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy_i,
    input jlt_pkg::cfg_t cfg_q,
    input logic          tap_vld,
    input logic          tms_o,
    input logic          tdi_o
);
    localparam int MAX_OFS = 2 ** jlt_pkg::OFS_W;

    logic [4:0] since_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             since_q <= '1;
        else if (tap_vld)       since_q <= '0;
        else if (since_q != '1) since_q <= since_q + 5'd1;
    end

    // R2: a pin only moves within the offset window after a pipeline tap
    a_r2_change_after_tap: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(tms_o) || !$stable(tdi_o)) |-> (since_q <= 5'(MAX_OFS)));

    // R4: the held link setting stays inside its legal range
    a_r4_link_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.link >= jlt_pkg::LINK_W'(LINK_MIN)) && (cfg_q.link <= jlt_pkg::LINK_W'(LINK_MAX)));

    // R6: equal offsets never let both pins move on the same edge
    a_r6_no_coincide: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_q.tms_ofs == cfg_q.tdi_ofs) && !$stable(tms_o)) |-> $stable(tdi_o));

    // R9: settings are frozen while the shift engine is busy
    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(cfg_q));
endmodule

bind jtag_launch_timer jlt_checker #(.LINK_MIN(LINK_MIN), .LINK_MAX(LINK_MAX)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy_i  (busy_i),
    .cfg_q   (cfg_q),
    .tap_vld (tap_vld),
    .tms_o   (tms_o),
    .tdi_o   (tdi_o)
);

// File: tb/sim_jtag_launch_timer.sv
module sim_jtag_launch_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       busy_i = 1'b0, no_rclk_i = 1'b0, rclk_i = 1'b0, tck_i = 1'b0;
    logic       fall_launch_i = 1'b0;
    logic [2:0] link_dly_i = 3'd3, tms_ofs_i = 3'd0, tdi_ofs_i = 3'd0;
    logic [1:0] byp_dly_i = 2'd0;
    logic       tms_nxt_i = 1'b0, tdi_nxt_i = 1'b0;
    logic       term_tck_i = 1'b0, term_tdi_i = 1'b0;
    logic       tms_o, tdi_o, term_en_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    jtag_launch_timer u0 (
        .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .no_rclk_i(no_rclk_i),
        .rclk_i(rclk_i), .tck_i(tck_i), .fall_launch_i(fall_launch_i),
        .link_dly_i(link_dly_i), .tms_ofs_i(tms_ofs_i), .tdi_ofs_i(tdi_ofs_i),
        .byp_dly_i(byp_dly_i), .tms_nxt_i(tms_nxt_i), .tdi_nxt_i(tdi_nxt_i),
        .term_tck_i(term_tck_i), .term_tdi_i(term_tdi_i),
        .tms_o(tms_o), .tdi_o(tdi_o), .term_en_o(term_en_o)
    );

    // vector: {link, tms offset, tdi offset, falling launch}
    localparam logic [9:0] VEC [8] = '{
        {3'd3, 3'd0, 3'd0, 1'b0},
        {3'd4, 3'd2, 3'd5, 1'b0},
        {3'd5, 3'd7, 3'd0, 1'b0},
        {3'd1, 3'd3, 3'd3, 1'b0},
        {3'd7, 3'd0, 3'd7, 1'b1},
        {3'd3, 3'd5, 3'd1, 1'b1},
        {3'd0, 3'd7, 3'd7, 1'b1},
        {3'd4, 3'd1, 3'd4, 1'b0}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clamp_link(input int l);
        return (l < 3) ? 3 : ((l > 5) ? 5 : l);
    endfunction

    function automatic int tdi_eff(input int t, input int d);
        return (t == d) ? d + 1 : d;
    endfunction

    task automatic set_cfg(input int l, input int t, input int d, input bit f,
                           input bit nr, input int b);
        @(negedge clk);
        link_dly_i = 3'(l); tms_ofs_i = 3'(t); tdi_ofs_i = 3'(d);
        fall_launch_i = f; no_rclk_i = nr; byp_dly_i = 2'(b);
        repeat (3) @(negedge clk);
    endtask

    // counts posedges until each pin reaches its wanted value; 0 = never
    task automatic measure(input bit wt, input bit wd, output int lt, output int ld);
        lt = 0; ld = 0;
        for (int k = 1; k <= 40; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (lt == 0 && tms_o == wt) lt = k;
            if (ld == 0 && tdi_o == wd) ld = k;
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int lt, ld, l, t, d;
        bit f, wt, wd;

        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 tms reset", int'(tms_o), 1);
        check("R1 tdi reset", int'(tdi_o), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 tms after release", int'(tms_o), 1);

        // table walk: R2 R3 R4 R5 R6
        foreach (VEC[i]) begin
            l = int'(VEC[i][9:7]); t = int'(VEC[i][6:4]);
            d = int'(VEC[i][3:1]); f = VEC[i][0];
            set_cfg(l, t, d, f, 1'b0, 0);
            wt = ~tms_o; wd = ~tdi_o;
            tms_nxt_i = wt; tdi_nxt_i = wd;
            if (f) begin
                rclk_i = 1'b1;
                measure(wt, wd, lt, ld);
                check("R3 rising ignored tms", lt, 0);
                check("R3 rising ignored tdi", ld, 0);
                rclk_i = 1'b0;
            end else begin
                rclk_i = 1'b1;
            end
            measure(wt, wd, lt, ld);
            check("R2 R4 tms latency", lt, clamp_link(l) + t + 1);
            check("R5 R6 tdi latency", ld, clamp_link(l) + tdi_eff(t, d) + 1);
            if (!f) begin
                rclk_i = 1'b0;
                repeat (20) @(negedge clk);
            end
        end

        // R7 loop-back with smallest and largest delay
        for (int b = 0; b < 4; b += 3) begin
            set_cfg(4, 1, 2, 1'b0, 1'b1, b);
            wt = ~tms_o; wd = ~tdi_o;
            tms_nxt_i = wt; tdi_nxt_i = wd;
            tck_i = 1'b1;
            measure(wt, wd, lt, ld);
            check("R7 bypass tms latency", lt, 4 + 1 + b + 2);
            check("R7 bypass tdi latency", ld, 4 + 2 + b + 2);
            // R8 external return clock ignored in loop-back mode
            tms_nxt_i = ~tms_o; tdi_nxt_i = ~tdi_o;
            rclk_i = 1'b1;
            measure(~tms_o, ~tdi_o, lt, ld);
            check("R8 rclk ignored tms", lt, 0);
            check("R8 rclk ignored tdi", ld, 0);
            rclk_i = 1'b0;
            tck_i = 1'b0;
            repeat (10) @(negedge clk);
        end

        // R9 settings frozen while busy
        set_cfg(3, 0, 1, 1'b0, 1'b0, 0);
        busy_i = 1'b1;
        link_dly_i = 3'd5; tms_ofs_i = 3'd7; tdi_ofs_i = 3'd6;
        repeat (3) @(negedge clk);
        wt = ~tms_o; wd = ~tdi_o;
        tms_nxt_i = wt; tdi_nxt_i = wd;
        rclk_i = 1'b1;
        measure(wt, wd, lt, ld);
        check("R9 frozen tms latency", lt, 4);
        check("R9 frozen tdi latency", ld, 5);
        rclk_i = 1'b0;
        busy_i = 1'b0;
        repeat (5) @(negedge clk);

        // R10 termination enable
        for (int c = 0; c < 4; c++) begin
            term_tck_i = c[0]; term_tdi_i = c[1];
            #1;
            check("R10 term enable", int'(term_en_o), (c != 0) ? 1 : 0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule